// File: doc/BRIEF.md
# Ordered Pausable Read Payload Streamer

This block hands finished 4 KB read payloads to the consumer over a 256-bit stream. Every queued read command owns one 4 KB slot of an internal buffer, and the slot number is the command ID. The producer side writes a payload into its slot through a plain write port and then pulses a fill strobe carrying the slot number. The streamer delivers payloads strictly in ascending command-ID order, wrapping at the last slot. It tags each beat with the ID being delivered. After the final beat of a slot it pulses a retire signal, so the owner of the command queue can free that entry.

Flow control is a pause input rather than a ready handshake. While pause is low and the current slot is filled, one beat goes out on every cycle. When pause goes high, the stream stops within a small bounded number of cycles, and it resumes the same way, with no beat lost or repeated. A slot that fills ahead of its turn waits until every earlier slot has been delivered.

Top module: `ordered_read_streamer`

## Requirements
- R1: After reset `valid_o` and `retire_o` are low, all slots are empty, and the first payload delivered is slot 0.
- R2: A payload is 128 beats, read from buffer addresses {slot, beat} in beat order 0..127. With `pause_i` low, `valid_o` stays high for 128 consecutive cycles and `data_o` equals the word written at each address.
- R3: When `pause_i` is sampled high, `valid_o` is low from the next cycle on, and always within 4 cycles. When `pause_i` is released it resumes within 4 cycles. No beat is dropped or repeated across a pause.
- R4: `id_o` carries the slot of the beat shown. It advances by one after each 128-beat payload and wraps from SLOTS-1 to 0.
- R5: A payload does not start until its slot has been marked filled by `fill_i` with `fill_id_i` equal to that slot. Until then `valid_o` stays low.
- R6: Slots filled out of order are still delivered in ascending ID order. A filled later slot never overtakes an unfilled earlier one.
- R7: `retire_o` is a one-cycle pulse in the cycle after the 128th beat, with `retire_id_o` equal to that payload's slot. The slot then counts as empty, so reaching it again after a wrap needs a new fill.
- R8: Consecutive filled slots stream back to back, with no idle cycle between the last beat of one and the first beat of the next.
- R9: `wr_en_i` writes `wr_data_i` to buffer address `wr_addr_i`. The slot occupies the upper SLOT_W bits of the address and the beat occupies the low 7 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Buffer write enable from the producer |
| wr_addr_i | input | SLOT_W+7 | Buffer write address {slot, beat} |
| wr_data_i | input | DATA_W | Buffer write data |
| fill_i | input | 1 | Strobe marking a slot as holding a complete payload |
| fill_id_i | input | SLOT_W | Slot marked by `fill_i` |
| pause_i | input | 1 | Consumer request to hold the stream |
| valid_o | output | 1 | Beat present on `data_o` |
| data_o | output | DATA_W | Payload beat |
| id_o | output | SLOT_W | Command ID of the current beat |
| retire_o | output | 1 | One-cycle pulse after a payload's last beat |
| retire_id_o | output | SLOT_W | Slot retired by `retire_o` |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the stream stops in the cycle after pause is sampled high;
- a slot is never cleared unless it is filled, so no payload is read from an unfilled slot;
- a retire pulse lasts a single cycle;
- each retire names the ID shown on the beat just before it.

Other behaviours only the bench scenarios can show. These are the payload contents and beat order, the 128-cycle run length, back-to-back delivery of adjacent slots, and holding a slot filled early behind an unfilled earlier one. They also include the wrap to slot 0 that needs a fresh fill, and beat continuity under a pause that toggles on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int BEAT_W = 7;            // 128 beats x 32 B = 4 KB
  localparam int BEATS  = 1 << BEAT_W;
endpackage

// File: rtl/rs_payload_ram.sv
module rs_payload_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/rs_slot_map.sv
module rs_slot_map #(
  parameter int SLOT_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    set_i,
  input  logic [SLOT_W-1:0]       set_id_i,
  input  logic                    clr_i,
  input  logic [SLOT_W-1:0]       clr_id_i,
  output logic [(1<<SLOT_W)-1:0]  filled_o
);
  localparam int SLOTS = 1 << SLOT_W;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bit_q <= 1'b0;
      else if (set_i && set_id_i == SLOT_W'(s))    bit_q <= 1'b1;
      else if (clr_i && clr_id_i == SLOT_W'(s))    bit_q <= 1'b0;
    end
    assign filled_o[s] = bit_q;
  end

  // R5: the sequencer only finishes payloads from slots that were filled
  a_r5_clear_only_filled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> filled_o[clr_id_i]);
endmodule

// File: rtl/rs_sequencer.sv
module rs_sequencer #(
  parameter int SLOT_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [(1<<SLOT_W)-1:0]        filled_i,
  input  logic                          pause_i,
  output logic                          rd_en_o,
  output logic [SLOT_W+rs_pkg::BEAT_W-1:0] rd_addr_o,
  output logic                          valid_o,
  output logic [SLOT_W-1:0]             id_o,
  output logic                          clr_o,
  output logic [SLOT_W-1:0]             clr_id_o,
  output logic                          retire_o,
  output logic [SLOT_W-1:0]             retire_id_o
);
  import rs_pkg::*;

  logic [SLOT_W-1:0] cur_id_q, id_q, ret_id_q;
  logic [BEAT_W-1:0] beat_q;
  logic              valid_q, last_q, retire_q;
  logic              issue, last;

  assign issue = filled_i[cur_id_q] & ~pause_i;
  assign last  = issue && (beat_q == BEAT_W'(BEATS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_id_q <= '0;
      id_q     <= '0;
      ret_id_q <= '0;
      beat_q   <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      retire_q <= 1'b0;
    end else begin
      valid_q  <= issue;
      last_q   <= last;
      retire_q <= last_q;
      if (last_q) ret_id_q <= id_q;  // id_q still tags the final beat here
      if (issue) begin
        id_q   <= cur_id_q;
        beat_q <= beat_q + BEAT_W'(1);
        if (last) cur_id_q <= cur_id_q + SLOT_W'(1);
      end
    end
  end

  assign rd_en_o     = issue;
  assign rd_addr_o   = {cur_id_q, beat_q};
  assign valid_o     = valid_q;
  assign id_o        = id_q;
  assign clr_o       = last;
  assign clr_id_o    = cur_id_q;
  assign retire_o    = retire_q;
  assign retire_id_o = ret_id_q;

  // R3: stream halts the cycle after pause is seen
  a_r3_pause_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !valid_o);
endmodule

// File: rtl/ordered_read_streamer.sv
module ordered_read_streamer #(
  parameter int SLOT_W = 2,
  parameter int DATA_W = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [SLOT_W+rs_pkg::BEAT_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          fill_i,
  input  logic [SLOT_W-1:0]             fill_id_i,
  input  logic                          pause_i,
  output logic                          valid_o,
  output logic [DATA_W-1:0]             data_o,
  output logic [SLOT_W-1:0]             id_o,
  output logic                          retire_o,
  output logic [SLOT_W-1:0]             retire_id_o
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int ADDR_W = SLOT_W + rs_pkg::BEAT_W;

  logic [SLOTS-1:0]  filled;
  logic              rd_en, clr;
  logic [ADDR_W-1:0] rd_addr;
  logic [SLOT_W-1:0] clr_id;

  rs_slot_map #(.SLOT_W(SLOT_W)) u_map (
    .clk_i, .rst_ni,
    .set_i(fill_i), .set_id_i(fill_id_i),
    .clr_i(clr), .clr_id_i(clr_id),
    .filled_o(filled)
  );

  rs_sequencer #(.SLOT_W(SLOT_W)) u_seq (
    .clk_i, .rst_ni,
    .filled_i(filled), .pause_i,
    .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .valid_o, .id_o,
    .clr_o(clr), .clr_id_o(clr_id),
    .retire_o, .retire_id_o
  );

  rs_payload_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i,
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(data_o)
  );

  // R7: retire is a single-cycle pulse
  a_r7_retire_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
  // R7: retire names the slot of the beat just delivered
  a_r7_retire_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> (retire_id_o == $past(id_o)));
endmodule

// File: tb/ordered_read_streamer_tb.sv
module ordered_read_streamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W = 2;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int DATA_W = 256;

  logic              clk = 1'b0;
  logic              rst_ni, wr_en_i, fill_i, pause_i;
  logic [SLOT_W+6:0] wr_addr_i;
  logic [DATA_W-1:0] wr_data_i;
  logic [SLOT_W-1:0] fill_id_i;
  logic              valid_o, retire_o;
  logic [DATA_W-1:0] data_o;
  logic [SLOT_W-1:0] id_o, retire_id_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  ordered_read_streamer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .fill_i, .fill_id_i, .pause_i,
    .valid_o, .data_o, .id_o, .retire_o, .retire_id_o
  );

  int total = 0, bad = 0;
  int gen_of [SLOTS];
  int exp_id = 0, exp_beat = 0, beats_total = 0, retires_total = 0;
  bit mon_on = 1'b0, ret_due = 1'b0;
  int ret_due_id = 0;

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(int id, int gen, int beat);
    logic [DATA_W-1:0] r;
    for (int w = 0; w < DATA_W/32; w++)
      r[w*32 +: 32] = 32'(id*16777216 + gen*65536 + beat*256 + w);
    return r;
  endfunction

  // Monitor: sampled on the falling edge
  always @(negedge clk) if (mon_on) begin
    bit nxt_due;
    int nxt_id;
    nxt_due = 1'b0;
    nxt_id  = 0;
    if (retire_o) retires_total++;
    if (ret_due || retire_o)
      check(retire_o === ret_due && (!ret_due || retire_id_o == SLOT_W'(ret_due_id)), "R7",
            $sformatf("retire act=%0b/%0d exp=%0b/%0d", retire_o, retire_id_o, ret_due, ret_due_id));
    if (valid_o) begin
      check(id_o == SLOT_W'(exp_id), "R4",
            $sformatf("id act=%0d exp=%0d", id_o, exp_id));
      check(data_o == pat(exp_id, gen_of[exp_id], exp_beat), "R2",
            $sformatf("data act=%h exp=%h", data_o, pat(exp_id, gen_of[exp_id], exp_beat)));
      beats_total++;
      if (exp_beat == 127) begin
        nxt_due  = 1'b1;
        nxt_id   = exp_id;
        exp_id   = (exp_id + 1) % SLOTS;
        exp_beat = 0;
      end else exp_beat++;
    end
    ret_due    = nxt_due;
    ret_due_id = nxt_id;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input int s, input int gen);
    for (int b = 0; b < 128; b++) begin
      step();
      wr_en_i   = 1'b1;
      wr_addr_i = {SLOT_W'(s), 7'(b)};
      wr_data_i = pat(s, gen, b);
    end
    step();
    wr_en_i = 1'b0;
    gen_of[s] = gen;
  endtask

  task automatic fill(input int s);
    step();
    fill_i = 1'b1;
    fill_id_i = SLOT_W'(s);
    step();
    fill_i = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string req);
    bit seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (valid_o) seen = 1'b1;
    end
    check(!seen, req, $sformatf("valid act=%0b exp=0 over %0d cycles", seen, n));
  endtask

  task automatic measure_run(output int run);
    int waited = 0;
    run = 0;
    @(negedge clk);
    while (!valid_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    while (valid_o && run < 2000) begin
      run++;
      @(negedge clk);
    end
  endtask

  task automatic wait_exp(input int id, input int beat);
    int n = 0;
    while (!(exp_id == id && exp_beat >= beat) && n < 5000) begin
      step();
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int run;
    int k;
    rst_ni = 1'b0; wr_en_i = 1'b0; fill_i = 1'b0; pause_i = 1'b0;
    wr_addr_i = '0; wr_data_i = '0; fill_id_i = '0;
    for (int s = 0; s < SLOTS; s++) gen_of[s] = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0 && retire_o == 1'b0, "R1",
          $sformatf("reset valid/retire act=%0b/%0b exp=0/0", valid_o, retire_o));
    mon_on = 1'b1;

    for (int s = 0; s < SLOTS; s++) load(s, 0);   // R9 writes
    expect_idle(20, "R5");

    // R1/R2: slot 0 first, 128-beat run
    fill(0);
    measure_run(run);
    check(run == 128, "R2", $sformatf("run act=%0d exp=128", run));
    expect_idle(10, "R5");

    // R6: slot 2 early must wait for slot 1; R8: 1 and 2 back to back
    fill(2);
    expect_idle(20, "R6");
    fill(1);
    measure_run(run);
    check(run == 256, "R8", $sformatf("run act=%0d exp=256", run));
    check(exp_id == 3, "R6", $sformatf("next id act=%0d exp=3", exp_id));

    // R3: pause in the middle of slot 3
    fill(3);
    wait_exp(3, 10);
    pause_i = 1'b1;
    k = 0;
    repeat (4) begin
      @(negedge clk);
      k++;
    end
    check(valid_o == 1'b0, "R3", $sformatf("valid after pause act=%0b exp=0", valid_o));
    expect_idle(16, "R3");
    step();
    pause_i = 1'b0;
    k = 0;
    repeat (4) begin
      @(negedge clk);
      k++;
    end
    check(valid_o == 1'b1, "R3", $sformatf("valid after release act=%0b exp=1", valid_o));
    wait_exp(0, 0);
    repeat (3) @(negedge clk);
    check(retires_total == 4, "R7", $sformatf("retires act=%0d exp=4", retires_total));

    // R7: slot 0 was retired, so wrapping to it waits for a new fill
    expect_idle(20, "R7");
    load(0, 1);
    fill(0);
    for (int c = 0; c < 60; c++) begin
      step();
      pause_i = c[0];
    end
    step();
    pause_i = 1'b0;
    wait_exp(1, 0);
    repeat (3) @(negedge clk);
    check(beats_total == 5*128, "R3", $sformatf("beats act=%0d exp=%0d", beats_total, 5*128));
    check(retires_total == 5, "R4", $sformatf("retires act=%0d exp=5", retires_total));
    check(exp_id == 1 && valid_o == 1'b0, "R4",
          $sformatf("wrap id act=%0d exp=1", exp_id));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule